// File: doc/BRIEF.md
# Boost PFC Deadbeat Current Controller with Disturbance Estimation

This block computes, once per switching period, the duty command for the inductor current loop of a boost power-factor stage that has no input-voltage sensor. Each sample strobe delivers the period-average inductor current, the output voltage, a reference amplitude from the outer voltage loop and a programmable gain. The block returns a new duty command and an estimate of the unmeasured disturbance, which tracks the rectified line voltage.

The law is predictive. It picks the switch-off fraction that drives the current to the applied reference by the end of the next period, and it leaves out the line-voltage term. Whatever that omitted term does shows up as a current error one period later. The estimator reads that error as the measured current minus the reference applied in the previous period. The same estimate has two uses. First, scaled by the amplitude, it forms the sinusoidal current reference. Second, it is subtracted from that reference as feedforward.

The gain is the modelled inductance over the period, in fixed point. The division by the output voltage is done by a short sequential divider. All of this finishes in a few tens of clocks after the strobe, which is negligible next to a switching period. For stability margin, the gain should be set from an inductance somewhat below nominal.

Top module: `pfc_deadbeat_ctrl`

## Requirements
- R1: While rst_n is low or enable is low, duty_o, est_o, clamp_o and done_o are 0, and the estimator's stored previous reference is 0. The first sample after either event therefore yields est_o equal to the measured current.
- R2: A sample_stb seen while enabled and idle captures all four sample inputs and starts one computation. That computation ends with done_o high for exactly one cycle, within DW+6 cycles. A strobe that arrives while busy or while disabled is ignored.
- R3: The estimate is the measured current minus the applied reference stored from the previous computation (0 after clear). It is saturated to a signed DW+4 bit range.
- R4: The reference shape is (ref_amp * estimate) arithmetically shifted right by AFRAC (ref_amp unsigned, 256 = 1.0 by default). The applied reference is shape minus estimate, saturated to DW+4 bits, and it is stored for the next period.
- R5: The voltage term v = (gain_k * (i_meas - applied reference)) >>> GSHIFT. When 0 < v < v_out, the complement duty is floor(v * 2^DW / v_out) and duty_o = 2^DW minus that, with clamp_o low.
- R6: When v <= 0, duty_o = 2^DW (full on). clamp_o is high only if v < 0.
- R7: When v > 0 and v >= v_out (including v_out = 0), duty_o = 0 and clamp_o is high.
- R8: duty_o, est_o and clamp_o change only in the cycle done_o rises, or on clear. Input changes without a strobe leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller run; low clears all state |
| sample_stb | input | 1 | Sample strobe, one per switching period |
| i_meas | input | DW | Sampled average inductor current, unsigned |
| v_out | input | DW | Sampled output voltage, unsigned |
| ref_amp | input | AW | Reference amplitude, unsigned, AFRAC fraction bits |
| gain_k | input | GW | Proportional gain, unsigned, GSHIFT fraction bits |
| duty_o | output | DW+1 | Duty command, 0 to 2^DW |
| est_o | output | DW+4 | Disturbance estimate, signed |
| clamp_o | output | 1 | Duty was forced to a rail |
| done_o | output | 1 | One-cycle pulse when outputs update |

## Verification
The bench walks the estimator's delay line over consecutive samples. A design that used the unadjusted shape, or the current period's reference, in place of the stored applied reference would report the wrong estimate on the second and later samples. Both rails are driven, including the exact v = 0 boundary. That boundary catches a clamp flag raised on a plain full-on result, and v_out = 0 catches a division by zero. Disable and busy-strobe scenarios show whether a stale delay line leaks past clear and whether a second strobe restarts a computation midway, which would emit two done pulses or the wrong duty.

// File: rtl/pfc_dbc_pkg.sv
package pfc_dbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ESTIMATE = 3'd1,
    ST_SCALE    = 3'd2,
    ST_DIVIDE   = 3'd3,
    ST_UPDATE   = 3'd4
  } dbc_state_e;

endpackage

// File: rtl/dbc_observer.sv
module dbc_observer #(
  parameter int DW = 10,
  parameter int IW = DW + 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 commit,
  input  logic        [DW-1:0] i_meas,
  input  logic signed [IW-1:0] ref_eff,
  output logic signed [IW-1:0] est
);
  localparam int XW = IW + 1;

  logic signed [IW-1:0] ref_prev_q;
  logic signed [IW-1:0] ref_prev_d;
  logic signed [XW-1:0] diff;

  // delay line holding the reference applied one period earlier
  always_comb begin
    ref_prev_d = ref_prev_q;
    if (clr)         ref_prev_d = '0;
    else if (commit) ref_prev_d = ref_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_prev_q <= '0;
    else        ref_prev_q <= ref_prev_d;
  end

  // measured current minus previous applied reference, saturated
  always_comb begin
    diff = $signed({{(XW-DW){1'b0}}, i_meas}) - $signed({ref_prev_q[IW-1], ref_prev_q});
    if (diff[XW-1] != diff[XW-2])
      est = diff[XW-1] ? {1'b1, {(IW-1){1'b0}}} : {1'b0, {(IW-1){1'b1}}};
    else
      est = diff[IW-1:0];
  end
endmodule

// File: rtl/dbc_refgen.sv
module dbc_refgen #(
  parameter int IW    = 14,
  parameter int AW    = 10,
  parameter int AFRAC = 8
) (
  input  logic signed [IW-1:0] est,
  input  logic        [AW-1:0] amp,
  output logic signed [IW-1:0] ref_eff
);
  localparam int PW = AW + IW + 1;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] SMAX = {{(SW-IW+1){1'b0}}, {(IW-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN = {{(SW-IW+1){1'b1}}, {(IW-1){1'b0}}};

  logic signed [PW-1:0] amp_x;
  logic signed [PW-1:0] est_x;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shape;
  logic signed [SW-1:0] sub;

  always_comb begin
    amp_x = $signed({{(PW-AW){1'b0}}, amp});
    est_x = $signed({{(PW-IW){est[IW-1]}}, est});
    prod  = amp_x * est_x;
    shape = prod >>> AFRAC;
    // feedforward: subtract the estimate from the shaped reference
    sub   = $signed({shape[PW-1], shape}) - $signed({est_x[PW-1], est_x});
    if (sub > SMAX)      ref_eff = SMAX[IW-1:0];
    else if (sub < SMIN) ref_eff = SMIN[IW-1:0];
    else                 ref_eff = sub[IW-1:0];
  end
endmodule

// File: rtl/dbc_gain.sv
module dbc_gain #(
  parameter int DW     = 10,
  parameter int IW     = DW + 4,
  parameter int GW     = 12,
  parameter int GSHIFT = 8,
  parameter int VW     = GW + IW + 3
) (
  input  logic        [DW-1:0] i_meas,
  input  logic signed [IW-1:0] ref_eff,
  input  logic        [GW-1:0] gain,
  output logic signed [VW-1:0] v_drop
);
  localparam int EW = IW + 2;

  logic signed [EW-1:0] err;
  logic signed [VW-1:0] err_x;
  logic signed [VW-1:0] k_x;
  logic signed [VW-1:0] prod;

  always_comb begin
    err    = $signed({{(EW-DW){1'b0}}, i_meas}) - $signed({{(EW-IW){ref_eff[IW-1]}}, ref_eff});
    err_x  = $signed({{(VW-EW){err[EW-1]}}, err});
    k_x    = $signed({{(VW-GW){1'b0}}, gain});
    prod   = k_x * err_x;
    v_drop = prod >>> GSHIFT;
  end
endmodule

// File: rtl/dbc_divider.sv
module dbc_divider #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [DW-1:0] quo,
  output logic          valid
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW:0]   rem_q, rem_d, rem_sh, den_x;
  logic [DW-1:0] quo_q, quo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          valid_q, valid_d;
  logic          ge;

  // restoring division of num*2^DW by den, num < den, one bit per cycle
  always_comb begin
    rem_sh  = {rem_q[DW-1:0], 1'b0};
    den_x   = {1'b0, den};
    ge      = rem_q[DW] | (rem_sh >= den_x);
    rem_d   = rem_q;
    quo_d   = quo_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    valid_d = 1'b0;
    if (clr) begin
      rem_d  = '0;
      quo_d  = '0;
      cnt_d  = '0;
      busy_d = 1'b0;
    end else if (start) begin
      rem_d  = {1'b0, num};
      quo_d  = '0;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = ge ? (rem_sh - den_x) : rem_sh;
      quo_d = {quo_q[DW-2:0], ge};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d  = 1'b0;
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      quo_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      rem_q   <= rem_d;
      quo_q   <= quo_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      valid_q <= valid_d;
    end
  end

  assign quo   = quo_q;
  assign valid = valid_q;
endmodule

// File: rtl/pfc_deadbeat_ctrl.sv
module pfc_deadbeat_ctrl #(
  parameter int DW     = 10,
  parameter int AW     = 10,
  parameter int AFRAC  = 8,
  parameter int GW     = 12,
  parameter int GSHIFT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 sample_stb,
  input  logic        [DW-1:0] i_meas,
  input  logic        [DW-1:0] v_out,
  input  logic        [AW-1:0] ref_amp,
  input  logic        [GW-1:0] gain_k,
  output logic        [DW:0]   duty_o,
  output logic signed [DW+3:0] est_o,
  output logic                 clamp_o,
  output logic                 done_o
);
  import pfc_dbc_pkg::*;

  localparam int IW = DW + 4;
  localparam int VW = GW + IW + 3;
  localparam logic [DW:0] DUTY_FS = {1'b1, {DW{1'b0}}};

  dbc_state_e state_q, state_d;

  logic        [DW-1:0] i_q, i_d, vo_q, vo_d;
  logic        [AW-1:0] amp_q, amp_d;
  logic        [GW-1:0] k_q, k_d;
  logic signed [IW-1:0] est_q, est_d, reff_q, reff_d;
  logic        [DW:0]   pend_duty_q, pend_duty_d, duty_q, duty_d;
  logic                 pend_clamp_q, pend_clamp_d, clamp_q, clamp_d;
  logic signed [IW-1:0] est_out_q, est_out_d;
  logic                 done_q, done_d;

  logic signed [IW-1:0] est_raw, reff_raw;
  logic signed [VW-1:0] v_raw, vo_x;
  logic                 v_le0, v_neg, v_ge_vo;
  logic                 div_start, div_valid;
  logic        [DW-1:0] div_q;
  logic                 clr;
  logic                 busy;

  assign clr  = ~enable;
  assign busy = (state_q != ST_IDLE);

  dbc_observer #(.DW(DW), .IW(IW)) u_obs (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .commit (state_q == ST_UPDATE),
    .i_meas (i_q),
    .ref_eff(reff_q),
    .est    (est_raw)
  );

  dbc_refgen #(.IW(IW), .AW(AW), .AFRAC(AFRAC)) u_ref (
    .est    (est_q),
    .amp    (amp_q),
    .ref_eff(reff_raw)
  );

  dbc_gain #(.DW(DW), .IW(IW), .GW(GW), .GSHIFT(GSHIFT), .VW(VW)) u_gain (
    .i_meas (i_q),
    .ref_eff(reff_raw),
    .gain   (k_q),
    .v_drop (v_raw)
  );

  dbc_divider #(.DW(DW)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .start(div_start),
    .num  (v_raw[DW-1:0]),
    .den  (vo_q),
    .quo  (div_q),
    .valid(div_valid)
  );

  always_comb begin
    vo_x      = $signed({{(VW-DW){1'b0}}, vo_q});
    v_neg     = v_raw[VW-1];
    v_le0     = v_neg | (v_raw == '0);
    v_ge_vo   = (v_raw >= vo_x);
    div_start = enable && (state_q == ST_SCALE) && !v_le0 && !v_ge_vo;
  end

  // next-state and datapath enables
  always_comb begin
    state_d      = state_q;
    i_d          = i_q;
    vo_d         = vo_q;
    amp_d        = amp_q;
    k_d          = k_q;
    est_d        = est_q;
    reff_d       = reff_q;
    pend_duty_d  = pend_duty_q;
    pend_clamp_d = pend_clamp_q;
    duty_d       = duty_q;
    clamp_d      = clamp_q;
    est_out_d    = est_out_q;
    done_d       = 1'b0;
    if (clr) begin
      state_d      = ST_IDLE;
      est_d        = '0;
      reff_d       = '0;
      pend_duty_d  = '0;
      pend_clamp_d = 1'b0;
      duty_d       = '0;
      clamp_d      = 1'b0;
      est_out_d    = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (sample_stb) begin
            i_d     = i_meas;
            vo_d    = v_out;
            amp_d   = ref_amp;
            k_d     = gain_k;
            state_d = ST_ESTIMATE;
          end
        end
        ST_ESTIMATE: begin
          est_d   = est_raw;
          state_d = ST_SCALE;
        end
        ST_SCALE: begin
          reff_d = reff_raw;
          if (v_le0) begin
            pend_duty_d  = DUTY_FS;
            pend_clamp_d = v_neg;
            state_d      = ST_UPDATE;
          end else if (v_ge_vo) begin
            pend_duty_d  = '0;
            pend_clamp_d = 1'b1;
            state_d      = ST_UPDATE;
          end else begin
            state_d = ST_DIVIDE;
          end
        end
        ST_DIVIDE: begin
          if (div_valid) begin
            pend_duty_d  = DUTY_FS - {1'b0, div_q};
            pend_clamp_d = 1'b0;
            state_d      = ST_UPDATE;
          end
        end
        ST_UPDATE: begin
          duty_d    = pend_duty_q;
          clamp_d   = pend_clamp_q;
          est_out_d = est_q;
          done_d    = 1'b1;
          state_d   = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      i_q          <= '0;
      vo_q         <= '0;
      amp_q        <= '0;
      k_q          <= '0;
      est_q        <= '0;
      reff_q       <= '0;
      pend_duty_q  <= '0;
      pend_clamp_q <= 1'b0;
      duty_q       <= '0;
      clamp_q      <= 1'b0;
      est_out_q    <= '0;
      done_q       <= 1'b0;
    end else begin
      state_q      <= state_d;
      i_q          <= i_d;
      vo_q         <= vo_d;
      amp_q        <= amp_d;
      k_q          <= k_d;
      est_q        <= est_d;
      reff_q       <= reff_d;
      pend_duty_q  <= pend_duty_d;
      pend_clamp_q <= pend_clamp_d;
      duty_q       <= duty_d;
      clamp_q      <= clamp_d;
      est_out_q    <= est_out_d;
      done_q       <= done_d;
    end
  end

  assign duty_o  = duty_q;
  assign est_o   = est_out_q;
  assign clamp_o = clamp_q;
  assign done_o  = done_q;
endmodule

// File: rtl/pfc_deadbeat_ctrl_chk.sv
module pfc_deadbeat_ctrl_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [DW:0]   duty_o,
  input logic [DW+3:0] est_o,
  input logic          clamp_o,
  input logic          done_o,
  input logic          busy
);
  localparam logic [DW:0] DUTY_FS = {1'b1, {DW{1'b0}}};
  localparam int LW = $clog2(DW + 8) + 1;
  localparam logic [LW-1:0] LAT_MAX = LW'(DW + 6);

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lat_q <= '0;
    else if (!busy)          lat_q <= '0;
    else if (lat_q != '1)    lat_q <= lat_q + 1'b1;
  end

  AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    duty_o <= DUTY_FS); // R5

  AST_CLAMP_ON_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_o |-> (duty_o == '0 || duty_o == DUTY_FS)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R2

  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q <= LAT_MAX); // R2

  AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (duty_o == '0 && est_o == '0 && !clamp_o && !done_o)); // R1

  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !done_o) |-> ($stable(duty_o) && $stable(est_o) && $stable(clamp_o))); // R8
endmodule

bind pfc_deadbeat_ctrl pfc_deadbeat_ctrl_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .enable (enable),
  .duty_o (duty_o),
  .est_o  (est_o),
  .clamp_o(clamp_o),
  .done_o (done_o),
  .busy   (busy)
);

// File: tb/pfc_deadbeat_ctrl_bench.sv
module pfc_deadbeat_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;
  localparam int AW = 10;
  localparam int GW = 12;
  localparam longint FS = 1024;
  localparam longint SMAX = 8191;
  localparam longint SMIN = -8192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          sample_stb = 1'b0;
  logic [DW-1:0] i_meas = '0;
  logic [DW-1:0] v_out = '0;
  logic [AW-1:0] ref_amp = '0;
  logic [GW-1:0] gain_k = '0;
  logic [DW:0]   duty_o;
  logic signed [DW+3:0] est_o;
  logic          clamp_o;
  logic          done_o;

  int n_checks = 0;
  int n_fail   = 0;
  longint ref_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfc_deadbeat_ctrl u_pfc_deadbeat_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sample_stb(sample_stb),
    .i_meas(i_meas), .v_out(v_out), .ref_amp(ref_amp), .gain_k(gain_k),
    .duty_o(duty_o), .est_o(est_o), .clamp_o(clamp_o), .done_o(done_o)
  );

  function automatic longint sat(input longint x);
    if (x > SMAX) return SMAX;
    if (x < SMIN) return SMIN;
    return x;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected outputs from the requirement formulas, updating the delay line
  task automatic model(input longint i, input longint vo, input longint amp, input longint k,
                       output longint d, output longint e, output longint c);
    longint shape, reff, v;
    e     = sat(i - ref_prev);
    shape = (amp * e) >>> 8;
    reff  = sat(shape - e);
    v     = (k * (i - reff)) >>> 8;
    if (v <= 0) begin
      d = FS; c = (v < 0) ? 1 : 0;
    end else if (v >= vo) begin
      d = 0; c = 1;
    end else begin
      d = FS - (v * FS) / vo; c = 0;
    end
    ref_prev = reff;
  endtask

  task automatic strobe(input int i, input int vo, input int amp, input int k);
    @(negedge clk);
    i_meas = DW'(i); v_out = DW'(vo); ref_amp = AW'(amp); gain_k = GW'(k);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  task automatic wait_done(output int dones, input int cycles);
    dones = 0;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (done_o) dones++;
    end
  endtask

  task automatic run_sample(input string req, input int i, input int vo, input int amp, input int k);
    longint d, e, c;
    int got = 0;
    model(i, vo, amp, k, d, e, c);
    strobe(i, vo, amp, k);
    for (int n = 0; n < 40 && got == 0; n++) begin
      if (done_o) got = 1;
      else @(negedge clk);
    end
    check({req, " done"}, got, 1);
    check({req, " duty"}, longint'(duty_o), d);
    check({req, " est"}, longint'(est_o), e);
    check({req, " clamp"}, longint'(clamp_o), c);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset duty", longint'(duty_o), 0);
    check("R1 reset est", longint'(est_o), 0);
    check("R1 reset clamp", longint'(clamp_o), 0);
    check("R1 reset done", longint'(done_o), 0);
  endtask

  task automatic t_delay_line;
    run_sample("R3 R5 first", 100, 400, 0, 256);   // duty 512, est 100
    run_sample("R3 second", 50, 400, 0, 256);      // est 150
    run_sample("R3 third", 300, 600, 0, 256);
  endtask

  task automatic t_shape;
    run_sample("R4 unity amp", 120, 500, 256, 256);
    run_sample("R4 half amp", 200, 700, 128, 256);
    run_sample("R5 half gain", 150, 500, 64, 128);
  endtask

  task automatic t_disable;
    int dn;
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check("R1 disable duty", longint'(duty_o), 0);
    check("R1 disable est", longint'(est_o), 0);
    strobe(100, 400, 0, 256);
    wait_done(dn, 30);
    check("R2 strobe while disabled", dn, 0);
    enable = 1'b1;
    ref_prev = 0;
    run_sample("R1 delay line cleared", 100, 400, 0, 256); // est 100
  endtask

  task automatic t_rails;
    @(negedge clk); enable = 1'b0; @(negedge clk); enable = 1'b1; ref_prev = 0;
    run_sample("R6 negative v", 100, 400, 1023, 256);  // v<0: full, clamp
    @(negedge clk); enable = 1'b0; @(negedge clk); enable = 1'b1; ref_prev = 0;
    run_sample("R6 zero v", 100, 400, 512, 256);       // v=0: full, no clamp
    run_sample("R7 v above vo", 1000, 50, 0, 256);
    run_sample("R7 vo zero", 500, 0, 0, 256);
  endtask

  task automatic t_busy_strobe;
    longint d, e, c;
    int dn;
    @(negedge clk); enable = 1'b0; @(negedge clk); enable = 1'b1; ref_prev = 0;
    model(200, 900, 0, 256, d, e, c);
    strobe(200, 900, 0, 256);
    @(negedge clk);
    strobe(700, 300, 300, 100);
    wait_done(dn, 40);
    check("R2 one done for busy strobe", dn, 1);
    check("R2 busy strobe duty", longint'(duty_o), d);
    check("R2 busy strobe est", longint'(est_o), e);
  endtask

  task automatic t_hold;
    logic [DW:0] d0;
    logic signed [DW+3:0] e0;
    d0 = duty_o; e0 = est_o;
    @(negedge clk);
    i_meas = 10'd999; v_out = 10'd3; ref_amp = 10'd700; gain_k = 12'd4000;
    repeat (25) @(negedge clk);
    check("R8 hold duty", longint'(duty_o), longint'(d0));
    check("R8 hold est", longint'(est_o), longint'(e0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    t_delay_line();
    t_shape();
    t_disable();
    t_rails();
    t_busy_strobe();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule